// File: doc/BRIEF.md
# Half-Precision Sign-Injection and Register Move Unit

This unit handles the bit-level half-precision operations of a floating-point pipeline whose register file is 64 bits wide. A 16-bit value sits in the low bits of a 64-bit register. It counts as valid only when every bit above it is one. This convention is called NaN-boxing.

The unit has three kinds of operation:
- Three sign-injection operations. Each reads two boxed operands, checks the box on both, and writes a boxed half-precision result.
- A raw move from a floating-point register to an integer register. It sign-extends the low 16 bits and applies no box check.
- A raw move from an integer register into a boxed floating-point value.

A function code and a sub-function field pick the operation. Any unsupported combination is flagged as illegal, and no result is offered for writing. Every result is registered, so the output valid follows the input valid by one clock.

Top module: `hsi_unit`

## Requirements
- R1: A source operand whose bits 63:16 are all ones is used as its low 16 bits. Any other source operand is replaced by the canonical half-precision NaN 16'h7E00 before sign injection.
- R2: Every legal floating-point result (res_is_int = 0) has bits 63:16 all ones.
- R3: With function code 7'h12 and sub-function 0, fp_res[14:0] equals bits 14:0 of the unboxed first operand, and fp_res[15] equals bit 15 of the unboxed second operand.
- R4: With function code 7'h12 and sub-function 1, fp_res[15] is the inverse of bit 15 of the unboxed second operand, and bits 14:0 are as in R3.
- R5: With function code 7'h12 and sub-function 2, fp_res[15] is the xor of bit 15 of both unboxed operands, and bits 14:0 are as in R3.
- R6: With function code 7'h72 and sub-function 0, int_res equals fp_a[15:0] sign-extended from bit 15 to 64 bits, whatever fp_a[63:16] holds, and res_is_int is 1.
- R7: With function code 7'h7A and sub-function 0, fp_res equals int_src[15:0] with bits 63:16 set to ones, and res_is_int is 0.
- R8: Any other sub-function under these three function codes, and any other function code, sets illegal to 1 and drives fp_res and int_res to zero with res_is_int at 0. Every legal operation sets illegal to 0.
- R9: out_valid is in_valid delayed by exactly one clock. A synchronous active-high reset clears out_valid, illegal, res_is_int and both results.
- R10: In a cycle with in_valid low, all result outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_funct | input | 7 | Function code |
| in_sub | input | 3 | Sub-function field |
| fp_a | input | 64 | First floating-point source register |
| fp_b | input | 64 | Second floating-point source register |
| int_src | input | 64 | Integer source register |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| fp_res | output | 64 | Floating-point result (boxed) |
| int_res | output | 64 | Integer result |
| res_is_int | output | 1 | 1 when the integer result is the one to write |
| illegal | output | 1 | Unsupported function/sub-function combination |

## Verification
The bench builds the unit with its default parameters: 64-bit floating-point and integer registers, a 16-bit value width and 16'h7E00 as the canonical NaN. With these values the box is 48 bits wide. Random operands are boxed correctly only half of the time, so both the NaN substitution of R1 and the unchecked raw move of R6 are reached often. Sign bits drawn at random cover all four sign combinations of the three sign-injection variants.

Directed cases cover the following:
- An operand with a single cleared box bit.
- Every illegal sub-function value and a stray function code.
- Idle cycles between operations, which exercise the hold behaviour.

// File: rtl/hsi_pkg.sv
package hsi_pkg;

  localparam logic [6:0] FN_SGNJ = 7'h12;
  localparam logic [6:0] FN_F2I  = 7'h72;
  localparam logic [6:0] FN_I2F  = 7'h7A;

  localparam logic [2:0] SUB_PLAIN = 3'd0;
  localparam logic [2:0] SUB_NEG   = 3'd1;
  localparam logic [2:0] SUB_XOR   = 3'd2;

  typedef enum logic [2:0] {
    OP_SGNJ  = 3'd0,
    OP_SGNJN = 3'd1,
    OP_SGNJX = 3'd2,
    OP_F2I   = 3'd3,
    OP_I2F   = 3'd4,
    OP_BAD   = 3'd7
  } hsi_op_e;

endpackage

// File: rtl/hsi_decode.sv
module hsi_decode
  import hsi_pkg::*;
(
  input  logic [6:0] funct,
  input  logic [2:0] sub,
  output hsi_op_e    op
);

  always_comb begin
    op = OP_BAD;
    unique case (funct)
      FN_SGNJ: begin
        case (sub)
          SUB_PLAIN: op = OP_SGNJ;
          SUB_NEG:   op = OP_SGNJN;
          SUB_XOR:   op = OP_SGNJX;
          default:   op = OP_BAD;
        endcase
      end
      FN_F2I:  op = (sub == 3'd0) ? OP_F2I : OP_BAD;
      FN_I2F:  op = (sub == 3'd0) ? OP_I2F : OP_BAD;
      default: op = OP_BAD;
    endcase
  end

endmodule

// File: rtl/hsi_unbox.sv
module hsi_unbox #(
  parameter int          FLEN      = 64,
  parameter int          HLEN      = 16,
  parameter logic [15:0] CANON_NAN = 16'h7E00
) (
  input  logic [FLEN-1:0] reg_in,
  output logic [HLEN-1:0] val_out
);

  localparam int BOXW = FLEN - HLEN;

  logic box_ok;

  assign box_ok  = &reg_in[FLEN-1:HLEN];
  assign val_out = box_ok ? reg_in[HLEN-1:0] : CANON_NAN[HLEN-1:0];

  initial begin
    assert (BOXW > 0) else $error("box width must be positive");
  end

endmodule

// File: rtl/hsi_sgnj.sv
module hsi_sgnj
  import hsi_pkg::*;
#(
  parameter int HLEN = 16
) (
  input  logic [HLEN-1:0] mag_src,
  input  logic [HLEN-1:0] sgn_src,
  input  hsi_op_e         op,
  output logic [HLEN-1:0] res
);

  localparam int SB = HLEN - 1;

  logic new_sign;

  always_comb begin
    case (op)
      OP_SGNJ:  new_sign = sgn_src[SB];
      OP_SGNJN: new_sign = ~sgn_src[SB];
      OP_SGNJX: new_sign = mag_src[SB] ^ sgn_src[SB];
      default:  new_sign = mag_src[SB];
    endcase
  end

  assign res = {new_sign, mag_src[SB-1:0]};

endmodule

// File: rtl/hsi_unit.sv
module hsi_unit
  import hsi_pkg::*;
#(
  parameter int          FLEN      = 64,
  parameter int          XLEN      = 64,
  parameter int          HLEN      = 16,
  parameter logic [15:0] CANON_NAN = 16'h7E00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [6:0]      in_funct,
  input  logic [2:0]      in_sub,
  input  logic [FLEN-1:0] fp_a,
  input  logic [FLEN-1:0] fp_b,
  input  logic [XLEN-1:0] int_src,
  output logic            out_valid,
  output logic [FLEN-1:0] fp_res,
  output logic [XLEN-1:0] int_res,
  output logic            res_is_int,
  output logic            illegal
);

  localparam int BOXW = FLEN - HLEN;
  localparam int EXTW = XLEN - HLEN;
  localparam int NSRC = 2;

  hsi_op_e         op;
  logic [FLEN-1:0] src   [NSRC];
  logic [HLEN-1:0] unbox [NSRC];
  logic [HLEN-1:0] sgnj_val;

  logic [FLEN-1:0] fp_nxt;
  logic [XLEN-1:0] int_nxt;
  logic            isint_nxt;
  logic            ill_nxt;

  assign src[0] = fp_a;
  assign src[1] = fp_b;

  hsi_decode u_dec (
    .funct (in_funct),
    .sub   (in_sub),
    .op    (op)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_unbox
    hsi_unbox #(
      .FLEN      (FLEN),
      .HLEN      (HLEN),
      .CANON_NAN (CANON_NAN)
    ) u_unbox (
      .reg_in  (src[g]),
      .val_out (unbox[g])
    );
  end

  hsi_sgnj #(.HLEN(HLEN)) u_sgnj (
    .mag_src (unbox[0]),
    .sgn_src (unbox[1]),
    .op      (op),
    .res     (sgnj_val)
  );

  always_comb begin
    fp_nxt    = '0;
    int_nxt   = '0;
    isint_nxt = 1'b0;
    ill_nxt   = 1'b0;
    case (op)
      OP_SGNJ, OP_SGNJN, OP_SGNJX: begin
        fp_nxt = {{BOXW{1'b1}}, sgnj_val};
      end
      OP_F2I: begin
        int_nxt   = {{EXTW{fp_a[HLEN-1]}}, fp_a[HLEN-1:0]};
        isint_nxt = 1'b1;
      end
      OP_I2F: begin
        fp_nxt = {{BOXW{1'b1}}, int_src[HLEN-1:0]};
      end
      default: begin
        ill_nxt = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      fp_res     <= '0;
      int_res    <= '0;
      res_is_int <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fp_res     <= fp_nxt;
        int_res    <= int_nxt;
        res_is_int <= isint_nxt;
        illegal    <= ill_nxt;
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R9
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);  // R9
  AST_FP_BOXED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !illegal && !res_is_int) |-> (&fp_res[FLEN-1:HLEN]));  // R2
  AST_INT_SEXT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && res_is_int) |->
      (int_res[XLEN-1:HLEN] == {EXTW{int_res[HLEN-1]}}));  // R6
  AST_ILLEGAL_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (fp_res == '0 && int_res == '0 && !res_is_int));  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(fp_res) && $stable(int_res) && $stable(illegal)));  // R10

endmodule

// File: tb/hsi_unit_test.sv
`timescale 1ns/1ps
module hsi_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [6:0]  in_funct = '0;
  logic [2:0]  in_sub = '0;
  logic [63:0] fp_a = '0, fp_b = '0, int_src = '0;
  logic        out_valid, res_is_int, illegal;
  logic [63:0] fp_res, int_res;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hsi_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_funct(in_funct),
    .in_sub(in_sub), .fp_a(fp_a), .fp_b(fp_b), .int_src(int_src),
    .out_valid(out_valid), .fp_res(fp_res), .int_res(int_res),
    .res_is_int(res_is_int), .illegal(illegal)
  );

  function automatic logic [15:0] unb(input logic [63:0] r);
    return (r[63:16] == {48{1'b1}}) ? r[15:0] : 16'h7E00;
  endfunction

  function automatic string tag_of(input logic [6:0] f, input logic [2:0] s);
    if (f == 7'h12 && s == 0) return "R3";
    if (f == 7'h12 && s == 1) return "R4";
    if (f == 7'h12 && s == 2) return "R5";
    if (f == 7'h72 && s == 0) return "R6";
    if (f == 7'h7A && s == 0) return "R7";
    return "R8";
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [6:0] f, input logic [2:0] s,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] i);
    logic [15:0] ua, ub, r;
    logic [63:0] e_fp, e_int;
    logic e_isint, e_ill;
    string t;
    @(negedge clk);
    in_valid = 1; in_funct = f; in_sub = s; fp_a = a; fp_b = b; int_src = i;
    ua = unb(a); ub = unb(b);
    e_fp = '0; e_int = '0; e_isint = 0; e_ill = 0;
    t = tag_of(f, s);
    if (t == "R3") begin r = {ub[15], ua[14:0]};         e_fp = {48'hFFFF_FFFF_FFFF, r}; end
    else if (t == "R4") begin r = {~ub[15], ua[14:0]};   e_fp = {48'hFFFF_FFFF_FFFF, r}; end
    else if (t == "R5") begin r = {ua[15]^ub[15], ua[14:0]}; e_fp = {48'hFFFF_FFFF_FFFF, r}; end
    else if (t == "R6") begin e_int = {{48{a[15]}}, a[15:0]}; e_isint = 1; end
    else if (t == "R7") e_fp = {48'hFFFF_FFFF_FFFF, i[15:0]};
    else e_ill = 1;
    @(posedge clk); #1;
    chk({t, " fp_res"}, fp_res, e_fp);
    chk({t, " int_res"}, int_res, e_int);
    chk({t, " res_is_int"}, {63'd0, res_is_int}, {63'd0, e_isint});
    chk({t, " illegal"}, {63'd0, illegal}, {63'd0, e_ill});
    chk("R9 out_valid", {63'd0, out_valid}, 64'd1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] hold_fp, hold_int;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R9 reset fp_res", fp_res, 64'd0);
    chk("R9 reset illegal", {63'd0, illegal}, 64'd0);
    @(negedge clk); rst = 0;

    // R1/R3: clean boxes and a single cleared box bit
    apply(7'h12, 0, 64'hFFFF_FFFF_FFFF_3C00, 64'hFFFF_FFFF_FFFF_8000, 0);
    apply(7'h12, 0, 64'hFFFF_FEFF_FFFF_3C00, 64'hFFFF_FFFF_FFFF_8000, 0); // R1 a unboxed
    chk("R1 nan magnitude", fp_res, 64'hFFFF_FFFF_FFFF_FE00);
    apply(7'h12, 1, 64'hFFFF_FFFF_FFFF_BC00, 64'h0000_0000_0000_0000, 0); // R1 b unboxed -> sign 0 inverted
    chk("R1 R4 nan sign", fp_res, 64'hFFFF_FFFF_FFFF_BC00);
    apply(7'h12, 2, 64'hFFFF_FFFF_FFFF_C000, 64'hFFFF_FFFF_FFFF_8001, 0); // R5
    // R6: unboxed upper bits ignored, negative sign
    apply(7'h72, 0, 64'h1234_5678_0000_8001, 0, 0);
    chk("R6 raw move", int_res, 64'hFFFF_FFFF_FFFF_8001);
    apply(7'h72, 0, 64'h0000_0000_0000_7FFF, 0, 0);
    // R7
    apply(7'h7A, 0, 0, 0, 64'h0123_4567_89AB_CDEF);
    chk("R7 boxed move", fp_res, 64'hFFFF_FFFF_FFFF_CDEF);
    // R8: every illegal sub-function plus stray codes
    for (int s = 3; s < 8; s++) apply(7'h12, s[2:0], 64'hFFFF_FFFF_FFFF_1111, 0, 0);
    for (int s = 1; s < 8; s++) apply(7'h72, s[2:0], 64'h8000, 0, 0);
    for (int s = 1; s < 8; s++) apply(7'h7A, s[2:0], 0, 0, 64'h5555);
    apply(7'h10, 0, 0, 0, 0);
    apply(7'h13, 2, 0, 0, 0);

    // R10: idle cycles hold the results
    apply(7'h7A, 0, 0, 0, 64'hAAAA);
    hold_fp = fp_res; hold_int = int_res;
    @(negedge clk);
    in_valid = 0; in_funct = 7'h72; fp_a = 64'hFFFF; int_src = 64'h1;
    @(posedge clk); #1;
    chk("R9 out_valid low", {63'd0, out_valid}, 64'd0);
    chk("R10 fp hold", fp_res, hold_fp);
    chk("R10 int hold", int_res, hold_int);
    repeat (2) @(posedge clk); #1;
    chk("R10 fp hold long", fp_res, hold_fp);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [6:0] f;
      logic [2:0] s;
      logic [63:0] a, b, i;
      int k;
      k = $urandom_range(0, 9);
      f = (k < 5) ? 7'h12 : (k < 7) ? 7'h72 : (k < 9) ? 7'h7A : 7'($urandom);
      s = ($urandom_range(0, 3) == 0) ? 3'($urandom) : ((f == 7'h12) ? 3'($urandom_range(0, 2)) : 3'd0);
      a = {$urandom, $urandom}; b = {$urandom, $urandom}; i = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 1) a[63:16] = '1;
      if ($urandom_range(0, 1) == 1) b[63:16] = '1;
      apply(f, s, a, b, i);
      if ($urandom_range(0, 4) == 0) begin
        @(negedge clk); in_valid = 0;
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule